// File: doc/BRIEF.md
# Torus Node Packet Router with Hub Route Table

This block is the forwarding element placed in every node of a two-dimensional wraparound mesh that carries control traffic between power converter controllers. It has five stream ports: one toward the local controller and one each toward the north, south, east and west neighbours. Every packet has a fixed number of beats. Its first beat, the header, names the destination and source coordinates and carries one flag that asks for hub routing. Each input buffers beats in a small FIFO. The router decides once per packet which output the packet leaves through, and that decision costs one clock cycle. The packet then keeps that output until its final beat has gone.

Ordinary traffic travels the shortest way around the ring in X until it reaches the destination column, and then travels in Y. Traffic to or from the single hub node may instead follow a precomputed per-node table. That table spreads the load evenly over the four links of the hub. A plain write port loads the table. When several inputs want the same output, a rotating priority serves them in turn. A packet that cannot move waits in its FIFO and is never sent on a longer path.

Top module: `torus_hub_router`

## Requirements
- R1: A packet whose header destination (bits [XW-1:0] = x, next YW bits = y) equals `node_x`/`node_y` leaves on the local port (index 0), whatever the hub flag and the table hold.
- R2: If the destination column differs from the node column, the packet leaves east (index 3, +x) or west (index 4, -x), whichever is fewer hops around the ring. A tie goes east. The Y coordinate has no effect on this choice.
- R3: If the column matches and the row differs, the packet leaves north (index 1, +y) or south (index 2, -y), whichever is fewer hops. A tie goes north.
- R4: If the hub flag (header bit 2*(XW+YW)) is set and the destination is the hub, the table is read at address ry*W+rx, where rx/ry are the source coordinates minus the hub coordinates, taken modulo W/H. If instead the source is the hub, the address is W*H + ry*W + rx, computed from the destination. Source fields sit directly above the destination fields in the header. Table codes 0..4 select an output by port index.
- R5: Table codes 5..7 (7 is the reset content), a clear hub flag, or a packet with neither endpoint at the hub all fall back to the routing of R2/R3. In those cases the table has no effect.
- R6: All PKT_BEATS beats of a packet leave the same output, in order and without beats of any other packet in between. Each input is served by at most one output at a time.
- R7: Inputs that compete for one output are served packet by packet in rotating order. After an input finishes a packet, the search starts from the next higher input index.
- R8: While `out_ready` is low, a presented beat holds its data. When an input FIFO (FIFO_DEPTH beats) is full, that input's `in_ready` drops. No beat is lost or duplicated.
- R9: A header accepted on clock edge t, at an idle input with a free output, is presented at the output after edge t+1.
- R10: During and right after reset, every `out_valid` is low and every `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_x | input | XW | Column of this node |
| node_y | input | YW | Row of this node |
| tbl_we | input | 1 | Route table write strobe |
| tbl_addr | input | TAW | Route table write address |
| tbl_code | input | 3 | Output code written (0 local, 1 N, 2 S, 3 E, 4 W, else invalid) |
| in_valid | input | 5 | Per-input beat valid |
| in_ready | output | 5 | Per-input FIFO has room |
| in_data | input | 5 x DW | Per-input beat data |
| out_valid | output | 5 | Per-output beat valid |
| out_ready | input | 5 | Per-output downstream can accept |
| out_data | output | 5 x DW | Per-output beat data |

## Verification
The bench uses a 4 x 4 ring with the node at column 1, row 2 and the hub at the origin. It uses four-beat packets and four-beat FIFOs. Even ring sizes make the exact half-way distance reachable in both dimensions, so both tie rules are tested. The hub sits off the node's row and column, so a table route differs visibly from the shortest-ring route. A FIFO exactly one packet deep means that holding one output shut fills the input with a whole packet and then drops its ready, while a second packet waits behind.

// File: rtl/torus_rt_pkg.sv
package torus_rt_pkg;
    localparam int NPORT = 5;
    localparam logic [2:0] PT_LOCAL = 3'd0;
    localparam logic [2:0] PT_NORTH = 3'd1;
    localparam logic [2:0] PT_SOUTH = 3'd2;
    localparam logic [2:0] PT_EAST  = 3'd3;
    localparam logic [2:0] PT_WEST  = 3'd4;
    localparam logic [2:0] PT_NONE  = 3'd7;
endpackage

// File: rtl/tr_fifo.sv
module tr_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          empty,
    output logic          full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [PW:0]   cnt;
    } st_t;

    st_t s_d, s_q;
    logic [DW-1:0] mem [DEPTH];

    always_comb begin
        s_d = s_q;
        if (wr_en) s_d.wp = (s_q.wp == PW'(DEPTH - 1)) ? '0 : s_q.wp + 1'b1;
        if (rd_en) s_d.rp = (s_q.rp == PW'(DEPTH - 1)) ? '0 : s_q.rp + 1'b1;
        if (wr_en && !rd_en) s_d.cnt = s_q.cnt + 1'b1;
        else if (rd_en && !wr_en) s_d.cnt = s_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[s_q.wp] <= wr_data;
    end

    assign rd_data = mem[s_q.rp];
    assign empty   = (s_q.cnt == '0);
    assign full    = (s_q.cnt == (PW+1)'(DEPTH));

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> !full);
    a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n) rd_en |-> !empty);
endmodule

// File: rtl/tr_route_table.sv
module tr_route_table #(
    parameter int W   = 4,
    parameter int H   = 4,
    parameter int NRD = 5
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    we,
    input  logic [$clog2(2*W*H)-1:0]                waddr,
    input  logic [2:0]                              wcode,
    input  logic [NRD-1:0][$clog2(2*W*H)-1:0]       raddr,
    output logic [NRD-1:0][2:0]                     rcode
);
    localparam int TBL_N = 2 * W * H;
    localparam int TAW   = $clog2(TBL_N);

    logic [2:0] tbl_d [TBL_N];
    logic [2:0] tbl_q [TBL_N];

    always_comb begin
        tbl_d = tbl_q;
        if (we && (int'(waddr) < TBL_N)) tbl_d[waddr] = wcode;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TBL_N; i++) tbl_q[i] <= torus_rt_pkg::PT_NONE;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rcode[r] = (int'(raddr[r]) < TBL_N) ? tbl_q[raddr[r]] : torus_rt_pkg::PT_NONE;
    end

    a_r4_table_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (int'(waddr) < TBL_N)) |=> (tbl_q[$past(waddr)] == $past(wcode)));

    localparam int UNUSED_TAW = TAW;
endmodule

// File: rtl/tr_in_unit.sv
module tr_in_unit
    import torus_rt_pkg::*;
#(
    parameter int W         = 4,
    parameter int H         = 4,
    parameter int PKT_BEATS = 4,
    parameter int HUB_X     = 0,
    parameter int HUB_Y     = 0
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic [((W > 1) ? $clog2(W) : 1)-1:0]        node_x,
    input  logic [((H > 1) ? $clog2(H) : 1)-1:0]        node_y,
    input  logic [2*(((W > 1) ? $clog2(W) : 1) + ((H > 1) ? $clog2(H) : 1)):0] hdr,
    input  logic                                        head_vld,
    input  logic                                        pop,
    input  logic [2:0]                                  tbl_code,
    output logic [$clog2(2*W*H)-1:0]                    tbl_addr,
    output logic                                        req_vld,
    output logic [2:0]                                  req_port,
    output logic                                        beat_last
);
    localparam int XW  = (W > 1) ? $clog2(W) : 1;
    localparam int YW  = (H > 1) ? $clog2(H) : 1;
    localparam int TAW = $clog2(2 * W * H);
    localparam int CW  = (PKT_BEATS > 1) ? $clog2(PKT_BEATS) : 1;

    typedef struct packed {
        logic          rvld;
        logic [2:0]    port;
        logic [CW-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    logic [XW-1:0] dest_x, src_x, end_x;
    logic [YW-1:0] dest_y, src_y, end_y;
    logic          hub_flag, dest_hub, src_hub, at_node;
    logic [2:0]    route;
    int            rx, ry, dxf, dyf, dir;

    always_comb begin
        dest_x   = hdr[XW-1:0];
        dest_y   = hdr[XW+YW-1:XW];
        src_x    = hdr[2*XW+YW-1:XW+YW];
        src_y    = hdr[2*XW+2*YW-1:2*XW+YW];
        hub_flag = hdr[2*XW+2*YW];
        dest_hub = (int'(dest_x) == HUB_X) && (int'(dest_y) == HUB_Y);
        src_hub  = (int'(src_x) == HUB_X) && (int'(src_y) == HUB_Y);
        at_node  = (dest_x == node_x) && (dest_y == node_y);
        end_x    = dest_hub ? src_x : dest_x;
        end_y    = dest_hub ? src_y : dest_y;
        dir      = dest_hub ? 0 : 1;
        rx       = (int'(end_x) + W - HUB_X) % W;
        ry       = (int'(end_y) + H - HUB_Y) % H;
        tbl_addr = TAW'(dir * W * H + ry * W + rx);
        dxf      = (int'(dest_x) + W - int'(node_x)) % W;
        dyf      = (int'(dest_y) + H - int'(node_y)) % H;

        if (at_node)
            route = PT_LOCAL;
        else if (hub_flag && (dest_hub || src_hub) && (tbl_code <= PT_WEST))
            route = tbl_code;
        else if (dxf != 0)
            route = (dxf <= W - dxf) ? PT_EAST : PT_WEST;
        else
            route = (dyf <= H - dyf) ? PT_NORTH : PT_SOUTH;
    end

    always_comb begin
        s_d = s_q;
        if (!s_q.rvld && head_vld) begin
            s_d.rvld = 1'b1;
            s_d.port = route;
        end
        if (s_q.rvld && pop) begin
            if (s_q.cnt == CW'(PKT_BEATS - 1)) begin
                s_d.cnt  = '0;
                s_d.rvld = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_vld   = s_q.rvld && head_vld;
    assign req_port  = s_q.port;
    assign beat_last = (s_q.cnt == CW'(PKT_BEATS - 1));

    // R1: a header addressed to this node is steered to the local port
    a_r1_local: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(s_q.rvld) && at_node) |-> (s_q.port == PT_LOCAL));
    // R2: a Y move is only taken once the column already matches
    a_r2_x_first: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(s_q.rvld) && !hub_flag && (s_q.port == PT_NORTH || s_q.port == PT_SOUTH))
        |-> (dest_x == node_x));
    a_r6_pop_owned: assert property (@(posedge clk) disable iff (!rst_n) pop |-> s_q.rvld);
endmodule

// File: rtl/tr_out_arb.sv
module tr_out_arb #(
    parameter int NIN = 5,
    parameter int DW  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NIN-1:0]          req,
    input  logic [NIN-1:0][DW-1:0]  data,
    input  logic [NIN-1:0]          last,
    input  logic                    ready,
    output logic [NIN-1:0]          gnt,
    output logic                    valid,
    output logic [DW-1:0]           data_o
);
    localparam int IW = (NIN > 1) ? $clog2(NIN) : 1;

    typedef struct packed {
        logic          locked;
        logic [IW-1:0] owner;
        logic [IW-1:0] ptr;
    } st_t;

    st_t s_d, s_q;

    logic [IW-1:0] pick, sel;
    logic          found;
    int            idx;

    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int k = 0; k < NIN; k++) begin
            idx = (int'(s_q.ptr) + k) % NIN;
            if (!found && req[idx]) begin
                found = 1'b1;
                pick  = IW'(idx);
            end
        end
        sel    = s_q.locked ? s_q.owner : pick;
        valid  = s_q.locked ? req[s_q.owner] : found;
        gnt    = '0;
        if (valid) gnt[sel] = 1'b1;
        data_o = data[sel];

        s_d = s_q;
        if (valid) begin
            if (ready && last[sel]) begin
                s_d.locked = 1'b0;
                s_d.ptr    = (int'(sel) == NIN - 1) ? '0 : sel + 1'b1;
            end else begin
                s_d.locked = 1'b1;
                s_d.owner  = sel;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R8: a stalled beat stays presented with unchanged data
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(data_o)));
    // R6: while a packet is open the output only serves its owner
    a_r6_locked_owner: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.locked |-> ($onehot0(gnt) && (gnt == '0 || gnt[s_q.owner])));
endmodule

// File: rtl/torus_hub_router.sv
module torus_hub_router
    import torus_rt_pkg::*;
#(
    parameter int W          = 4,
    parameter int H          = 4,
    parameter int DW         = 32,
    parameter int PKT_BEATS  = 4,
    parameter int FIFO_DEPTH = 4,
    parameter int HUB_X      = 0,
    parameter int HUB_Y      = 0
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [((W > 1) ? $clog2(W) : 1)-1:0]  node_x,
    input  logic [((H > 1) ? $clog2(H) : 1)-1:0]  node_y,
    input  logic                                  tbl_we,
    input  logic [$clog2(2*W*H)-1:0]              tbl_addr,
    input  logic [2:0]                            tbl_code,
    input  logic [4:0]                            in_valid,
    output logic [4:0]                            in_ready,
    input  logic [4:0][DW-1:0]                    in_data,
    output logic [4:0]                            out_valid,
    input  logic [4:0]                            out_ready,
    output logic [4:0][DW-1:0]                    out_data
);
    localparam int XW   = (W > 1) ? $clog2(W) : 1;
    localparam int YW   = (H > 1) ? $clog2(H) : 1;
    localparam int TAW  = $clog2(2 * W * H);
    localparam int HDRW = 2 * (XW + YW) + 1;

    logic [NPORT-1:0][DW-1:0]     head;
    logic [NPORT-1:0]             empty, full, pop, req_vld, beat_last;
    logic [NPORT-1:0][2:0]        req_port, rd_code;
    logic [NPORT-1:0][TAW-1:0]    rd_addr;
    logic [NPORT-1:0][NPORT-1:0]  req_map;   // [out][in]
    logic [NPORT-1:0][NPORT-1:0]  gnt;       // [out][in]
    logic [NPORT-1:0][NPORT-1:0]  gnt_by_in; // [in][out]

    tr_route_table #(.W(W), .H(H), .NRD(NPORT)) u_tbl (
        .clk(clk), .rst_n(rst_n), .we(tbl_we), .waddr(tbl_addr), .wcode(tbl_code),
        .raddr(rd_addr), .rcode(rd_code)
    );

    for (genvar i = 0; i < NPORT; i++) begin : g_in
        tr_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
            .clk(clk), .rst_n(rst_n),
            .wr_en(in_valid[i] && in_ready[i]), .wr_data(in_data[i]),
            .rd_en(pop[i]), .rd_data(head[i]), .empty(empty[i]), .full(full[i])
        );
        assign in_ready[i] = !full[i];

        tr_in_unit #(.W(W), .H(H), .PKT_BEATS(PKT_BEATS), .HUB_X(HUB_X), .HUB_Y(HUB_Y)) u_unit (
            .clk(clk), .rst_n(rst_n), .node_x(node_x), .node_y(node_y),
            .hdr(head[i][HDRW-1:0]), .head_vld(!empty[i]), .pop(pop[i]),
            .tbl_code(rd_code[i]), .tbl_addr(rd_addr[i]),
            .req_vld(req_vld[i]), .req_port(req_port[i]), .beat_last(beat_last[i])
        );
    end

    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            for (int i = 0; i < NPORT; i++) begin
                req_map[o][i]   = req_vld[i] && (req_port[i] == 3'(o));
                gnt_by_in[i][o] = gnt[o][i];
            end
        end
        for (int i = 0; i < NPORT; i++) pop[i] = |(gnt_by_in[i] & out_ready);
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        tr_out_arb #(.NIN(NPORT), .DW(DW)) u_arb (
            .clk(clk), .rst_n(rst_n), .req(req_map[o]), .data(head), .last(beat_last),
            .ready(out_ready[o]), .gnt(gnt[o]), .valid(out_valid[o]), .data_o(out_data[o])
        );
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_chk
        // R6: an input never feeds two outputs in the same cycle
        a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(gnt_by_in[i]));
    end
    // R10: nothing is presented in the first cycle after reset
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (out_valid == '0));
endmodule

// File: tb/torus_hub_router_test.sv
`timescale 1ns/1ps
module torus_hub_router_test;
    localparam int W = 4, H = 4, DW = 32, PB = 4, FD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] node_x = 2'd1, node_y = 2'd2;
    logic tbl_we = 1'b0;
    logic [4:0] tbl_addr = '0;
    logic [2:0] tbl_code = '0;
    logic [4:0] in_valid = '0;
    logic [4:0] in_ready;
    logic [4:0][DW-1:0] in_data = '0;
    logic [4:0] out_valid;
    logic [4:0] out_ready = 5'h1f;
    logic [4:0][DW-1:0] out_data;

    always #2.5 clk = ~clk;

    torus_hub_router #(.W(W), .H(H), .DW(DW), .PKT_BEATS(PB), .FIFO_DEPTH(FD),
                       .HUB_X(0), .HUB_Y(0)) uut (
        .clk(clk), .rst_n(rst_n), .node_x(node_x), .node_y(node_y),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_code(tbl_code),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0;
    int hdr_cyc [5];
    int first_cyc [5];
    logic [4:0] pv = '0;
    logic [DW-1:0] exp_q [5][$];
    string req_q [5][$];
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string r, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", r, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] beat(input int dx, dy, sx, sy, hub, tag, b);
        if (b == 0)
            return {16'(tag), 7'd0, 1'(hub), 2'(sy), 2'(sx), 2'(dy), 2'(dx)};
        return {16'(tag), 16'(b)};
    endfunction

    task automatic send(input int p, dx, dy, sx, sy, hub, tag, ep, input bit push, input string r);
        if (push)
            for (int b = 0; b < PB; b++) begin
                exp_q[ep].push_back(beat(dx, dy, sx, sy, hub, tag, b));
                req_q[ep].push_back(r);
            end
        for (int b = 0; b < PB; b++) begin
            @(negedge clk);
            in_valid[p] = 1'b1;
            in_data[p]  = beat(dx, dy, sx, sy, hub, tag, b);
            while (!in_ready[p]) @(negedge clk);
            if (b == 0) hdr_cyc[p] = cyc;
        end
        @(negedge clk);
        in_valid[p] = 1'b0;
    endtask

    task automatic expect_pkt(input int dx, dy, sx, sy, hub, tag, ep, input string r);
        for (int b = 0; b < PB; b++) begin
            exp_q[ep].push_back(beat(dx, dy, sx, sy, hub, tag, b));
            req_q[ep].push_back(r);
        end
    endtask

    task automatic drain(input string r);
        repeat (30) @(negedge clk);
        for (int j = 0; j < 5; j++)
            chk(exp_q[j].size() == 0, r, 32'(exp_q[j].size()), 32'd0);
    endtask

    task automatic tbl_write(input int a, input int c);
        @(posedge clk); #1;
        tbl_we = 1'b1; tbl_addr = 5'(a); tbl_code = 3'(c);
        @(posedge clk); #1;
        tbl_we = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            for (int j = 0; j < 5; j++) begin
                if (out_valid[j] && !pv[j]) first_cyc[j] = cyc;
                pv[j] = out_valid[j];
                if (out_valid[j] && out_ready[j]) begin
                    if (exp_q[j].size() == 0) begin
                        chk(1'b0, "R6 unexpected beat", out_data[j], '0);
                    end else begin
                        automatic logic [DW-1:0] w = exp_q[j].pop_front();
                        automatic string r = req_q[j].pop_front();
                        chk(out_data[j] == w, r, out_data[j], w);
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(out_valid == '0, "R10 valid in reset", 32'(out_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == '0, "R10 valid after reset", 32'(out_valid), 32'd0);
        chk(in_ready == 5'h1f, "R10 ready after reset", 32'(in_ready), 32'h1f);

        // R1 local delivery and R9 latency
        send(1, 1, 2, 3, 3, 1, 16'h0101, 0, 1, "R1 local");
        drain("R1 drained");
        chk(first_cyc[0] == hdr_cyc[1] + 2, "R9 latency", 32'(first_cyc[0]), 32'(hdr_cyc[1] + 2));

        // R2 X choice
        send(0, 0, 2, 1, 2, 0, 16'h0201, 4, 1, "R2 west");
        send(0, 3, 2, 1, 2, 0, 16'h0202, 3, 1, "R2 tie east");
        send(2, 2, 0, 1, 2, 0, 16'h0203, 3, 1, "R2 x before y");
        // R3 Y choice
        send(0, 1, 3, 1, 2, 0, 16'h0301, 1, 1, "R3 north");
        send(3, 1, 1, 1, 2, 0, 16'h0302, 2, 1, "R3 south");
        send(4, 1, 0, 1, 2, 0, 16'h0303, 1, 1, "R3 tie north");
        drain("R2 R3 drained");

        // R4 hub table
        tbl_write(15, 2);
        tbl_write(22, 1);
        send(3, 0, 0, 3, 3, 1, 16'h0401, 2, 1, "R4 toward hub");
        send(0, 2, 1, 0, 0, 1, 16'h0402, 1, 1, "R4 away from hub");
        // R5 fallbacks
        send(3, 0, 0, 3, 3, 0, 16'h0501, 4, 1, "R5 flag clear");
        send(1, 2, 2, 3, 3, 1, 16'h0502, 3, 1, "R5 no hub endpoint");
        send(2, 3, 0, 0, 0, 1, 16'h0503, 3, 1, "R5 reset entry");
        drain("R4 R5 drained");
        tbl_write(15, 6);
        send(3, 0, 0, 3, 3, 1, 16'h0504, 4, 1, "R5 invalid code");
        drain("R5 drained");

        // R7 rotation and R6 contiguity: two inputs, two packets each, one output
        expect_pkt(1, 2, 3, 2, 0, 16'h0701, 0, "R7 first east");
        expect_pkt(1, 2, 0, 2, 0, 16'h0702, 0, "R7 first west");
        expect_pkt(1, 2, 3, 2, 0, 16'h0703, 0, "R7 second east");
        expect_pkt(1, 2, 0, 2, 0, 16'h0704, 0, "R7 second west");
        fork
            begin
                send(3, 1, 2, 3, 2, 0, 16'h0701, 0, 0, "");
                send(3, 1, 2, 3, 2, 0, 16'h0703, 0, 0, "");
            end
            begin
                send(4, 1, 2, 0, 2, 0, 16'h0702, 0, 0, "");
                send(4, 1, 2, 0, 2, 0, 16'h0704, 0, 0, "");
            end
        join
        drain("R6 R7 drained");

        // R8 backpressure on the east output
        @(posedge clk); #1;
        out_ready[3] = 1'b0;
        fork
            begin
                send(1, 2, 2, 1, 1, 0, 16'h0801, 3, 1, "R8 stalled first");
                send(1, 2, 2, 1, 1, 0, 16'h0802, 3, 1, "R8 stalled second");
            end
            begin
                repeat (12) @(negedge clk);
                chk(in_ready[1] == 1'b0, "R8 ready drops", 32'(in_ready[1]), 32'd0);
                chk(out_valid[3] == 1'b1, "R8 beat held", 32'(out_valid[3]), 32'd1);
                chk(out_data[3] == beat(2, 2, 1, 1, 0, 16'h0801, 0), "R8 data held",
                    out_data[3], beat(2, 2, 1, 1, 0, 16'h0801, 0));
                @(posedge clk); #1;
                out_ready[3] = 1'b1;
            end
        join
        drain("R8 drained");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule